// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the synchronized input levels of one GPIO bank, up to 32 pins, and turns configured pin activity into a single interrupt request. Each pin is set on its own to trigger on a rising edge, a falling edge, both edges, a high level or a low level. Three configuration registers select the mode: a trigger-kind register, a polarity register and a both-edges register. A detected condition sets a sticky status bit. Software clears that bit by writing a one to it.

Masking is kept apart from detection. Two write-one strobe registers set and clear a per-pin mask, and a read-only view shows which pins are masked. The mask only gates the status bits on their way to the combined interrupt output. Detection and status capture go on for masked pins, so an event that arrives while a pin is masked raises the interrupt as soon as the pin is unmasked.

Register access uses a simple write port (enable, word address, data) and a combinational read port (address in, data out). Register word addresses: 0 mask view, 1 unmask strobe, 2 mask strobe, 3 status, 4 trigger kind, 5 polarity, 6 both-edges.

Top module: `gid_bank_irq`

## Requirements
- R1: After reset, every pin is masked (address 0 reads all ones), status reads 0, trigger kind, polarity and both-edges read 0, and `irq_o` is 0.
- R2: With trigger bit 1, polarity bit 1 and both-edges bit 0, a 0-to-1 change of the pin sets its status bit at the clock edge that first samples the new level. A 1-to-0 change sets nothing.
- R3: With trigger bit 1, polarity bit 0 and both-edges bit 0, a 1-to-0 change sets the status bit. A 0-to-1 change sets nothing.
- R4: With trigger bit 1 and both-edges bit 1, either change sets the status bit whatever the polarity bit holds.
- R5: With trigger bit 0, the status bit is set on every cycle in which the pin equals its polarity bit (1 means high, 0 means low). The both-edges bit has no effect in this mode.
- R6: Writing address 1 clears the mask bit of every pin whose data bit is 1. Writing address 2 sets the mask bit of every pin whose data bit is 1. Data bits of 0 leave the mask unchanged, and writing all ones to address 2 masks every pin.
- R7: Address 0 reads 1 for each masked pin. Addresses 1, 2 and 7 read 0.
- R8: `irq_o` is 1 exactly when some pin has its status bit set and its mask bit clear.
- R9: Writing address 3 clears the status bits whose data bits are 1. Status bits whose data bits are 0 are kept.
- R10: Status bits latch while a pin is masked, and unmasking a pin with a pending status raises `irq_o`.
- R11: A level-mode status bit cleared while its level is still active reads as set again afterwards.
- R12: When an event and a clear of the same status bit arrive in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address for writes |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Register word address for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives each edge mode in its inactive direction before its active one. A detector with swapped polarity, or one that fires on any change, therefore shows a status bit where none should be. A pin is made to fire while it is masked and then unmasked, so a design that stops detecting under mask never raises `irq_o`. A status clear is written in the same cycle as a fresh edge, and also while a level is still active, so a design where the clear wins ends up reading 0. Zero-valued writes to the strobe and status registers check that data bits of 0 change nothing.

// File: rtl/gid_pkg.sv
package gid_pkg;
   localparam int unsigned GID_REG_W = 3;

   typedef enum logic [GID_REG_W-1:0] {
      REG_MASKVIEW = 3'd0,
      REG_UNMASK   = 3'd1,
      REG_MASKSET  = 3'd2,
      REG_STATUS   = 3'd3,
      REG_TRIG     = 3'd4,
      REG_POL      = 3'd5,
      REG_BOTH     = 3'd6
   } gid_reg_e;
endpackage

// File: rtl/gid_detect.sv
module gid_detect #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_i,
   input  logic [NPINS-1:0] trig_i,
   input  logic [NPINS-1:0] pol_i,
   input  logic [NPINS-1:0] both_i,
   output logic [NPINS-1:0] evt_o
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_i;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic rise, fall, edge_hit, level_hit;
      assign rise      = pin_i[i] & ~prev_q[i];
      assign fall      = ~pin_i[i] & prev_q[i];
      assign edge_hit  = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
      assign level_hit = pol_i[i] ? pin_i[i] : ~pin_i[i];
      assign evt_o[i]  = trig_i[i] ? edge_hit : level_hit;
   end
endmodule

// File: rtl/gid_cfg_reg.sv
module gid_cfg_reg #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [NPINS-1:0] bits_i,
   output logic [NPINS-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= bits_i;
   end
endmodule

// File: rtl/gid_mask_status.sv
module gid_mask_status #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unmask_we_i,
   input  logic             mask_we_i,
   input  logic             clr_we_i,
   input  logic [NPINS-1:0] bits_i,
   input  logic [NPINS-1:0] evt_i,
   output logic [NPINS-1:0] mask_o,
   output logic [NPINS-1:0] status_o
);
   logic [NPINS-1:0] clr_bits;
   assign clr_bits = clr_we_i ? bits_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o <= '1;
      end else if (mask_we_i) begin
         mask_o <= mask_o | bits_i;
      end else if (unmask_we_i) begin
         mask_o <= mask_o & ~bits_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_o <= '0;
      else        status_o <= (status_o & ~clr_bits) | evt_i;
   end
endmodule

// File: rtl/gid_bank_irq.sv
module gid_bank_irq #(
   parameter int unsigned NPINS   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   import gid_pkg::*;

   localparam int unsigned NCFG = 3;

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gid_bank_irq: NPINS must be 1..DATA_W");
   end
   if (ADDR_W < GID_REG_W) begin : g_bad_addr
      $error("gid_bank_irq: ADDR_W too small for the register map");
   end

   logic [NPINS-1:0] wr_bits;
   logic [NPINS-1:0] mask_q, status_q, evt;
   logic [NPINS-1:0] cfg_q [NCFG];
   logic [NPINS-1:0] pend;

   assign wr_bits = wr_data[NPINS-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input gid_reg_e r);
      return a == ADDR_W'(r);
   endfunction

   for (genvar c = 0; c < NCFG; c++) begin : g_cfg
      localparam gid_reg_e RSEL = (c == 0) ? REG_TRIG : (c == 1) ? REG_POL : REG_BOTH;
      gid_cfg_reg #(.NPINS(NPINS)) cfg_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_i   (wr_en && hit(wr_addr, RSEL)),
         .bits_i (wr_bits),
         .q_o    (cfg_q[c])
      );
   end

   gid_detect #(.NPINS(NPINS)) det_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .trig_i (cfg_q[0]),
      .pol_i  (cfg_q[1]),
      .both_i (cfg_q[2]),
      .evt_o  (evt)
   );

   gid_mask_status #(.NPINS(NPINS)) ms_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .unmask_we_i (wr_en && hit(wr_addr, REG_UNMASK)),
      .mask_we_i   (wr_en && hit(wr_addr, REG_MASKSET)),
      .clr_we_i    (wr_en && hit(wr_addr, REG_STATUS)),
      .bits_i      (wr_bits),
      .evt_i       (evt),
      .mask_o      (mask_q),
      .status_o    (status_q)
   );

   always_comb begin
      rd_data = '0;
      if      (hit(rd_addr, REG_MASKVIEW)) rd_data[NPINS-1:0] = mask_q;
      else if (hit(rd_addr, REG_STATUS))   rd_data[NPINS-1:0] = status_q;
      else if (hit(rd_addr, REG_TRIG))     rd_data[NPINS-1:0] = cfg_q[0];
      else if (hit(rd_addr, REG_POL))      rd_data[NPINS-1:0] = cfg_q[1];
      else if (hit(rd_addr, REG_BOTH))     rd_data[NPINS-1:0] = cfg_q[2];
   end

   assign pend = status_q & ~mask_q;

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= |pend;
      end
   end else begin : g_irq_comb
      assign irq_o = |pend;
   end
endmodule

// File: rtl/gid_bank_irq_chk.sv
module gid_bank_irq_chk #(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [NPINS-1:0]  wr_bits,
   input logic [NPINS-1:0]  mask_q,
   input logic [NPINS-1:0]  status_q,
   input logic [NPINS-1:0]  evt
);
   logic unm_w, msk_w, clr_w;
   assign unm_w = wr_en && wr_addr == ADDR_W'(1);
   assign msk_w = wr_en && wr_addr == ADDR_W'(2);
   assign clr_w = wr_en && wr_addr == ADDR_W'(3);

   // R6: unmask strobe clears the addressed mask bits
   p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unm_w |=> (mask_q & $past(wr_bits)) == '0);

   // R6: mask strobe sets the addressed mask bits
   p_maskset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      msk_w |=> (mask_q & $past(wr_bits)) == $past(wr_bits));

   // R6: without a strobe the mask holds
   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(unm_w || msk_w) |=> $stable(mask_q));

   // R12: a detected event always lands in status, clear or not
   p_evt_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_q & $past(evt)) == $past(evt));

   // R9: cleared bits without a new event read 0
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> (status_q & $past(wr_bits & ~evt)) == '0);

   // R10: status never drops without a clear
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_w |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

bind gid_bank_irq gid_bank_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_bits  (wr_bits),
   .mask_q   (mask_q),
   .status_q (status_q),
   .evt      (evt)
);

// File: tb/gid_bank_irq_tb.sv
`timescale 1ns/1ps
module gid_bank_irq_tb_top;
   localparam int NP = 32;
   localparam logic [2:0] A_MASK = 3'd0, A_UNM = 3'd1, A_MSET = 3'd2,
                          A_STAT = 3'd3, A_TRIG = 3'd4, A_POL = 3'd5, A_BOTH = 3'd6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] pins = '1;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic irq_o;

   always #4 clk = ~clk;

   gid_bank_irq dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         act = it.is_irq ? {31'd0, irq_o} : rd_data;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      rd_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic exp_irq(input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
      q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic drive(input logic [NP-1:0] v);
      @(posedge clk); #1;
      pins = v;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      exp_rd(A_MASK, 32'hFFFF_FFFF, "R1 mask after reset");
      exp_rd(A_STAT, 32'h0, "R1 status after reset");
      exp_rd(A_TRIG, 32'h0, "R1 trigger after reset");
      exp_rd(A_POL,  32'h0, "R1 polarity after reset");
      exp_rd(A_BOTH, 32'h0, "R1 both after reset");
      exp_irq(1'b0, "R1 irq after reset");
      exp_rd(A_UNM, 32'h0, "R7 unmask strobe reads 0");
      // configure: all edge, low half rising, high half falling
      wr(A_TRIG, 32'hFFFF_FFFF);
      wr(A_POL,  32'h0000_FFFF);
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_UNM,  32'hFFFF_FFFF);
      exp_rd(A_MASK, 32'h0, "R6 unmask all");
      // R2 rising on pin 0
      drive(32'hFFFF_FFFE);
      exp_rd(A_STAT, 32'h0, "R2 falling ignored on rising pin");
      drive(32'hFFFF_FFFF);
      exp_rd(A_STAT, 32'h1, "R2 rising sets status");
      exp_irq(1'b1, "R8 irq with unmasked status");
      wr(A_STAT, 32'h1);
      exp_rd(A_STAT, 32'h0, "R9 write one clears");
      exp_irq(1'b0, "R8 irq low after clear");
      // R3 falling on pin 16
      drive(32'hFFFE_FFFF);
      exp_rd(A_STAT, 32'h0001_0000, "R3 falling sets status");
      drive(32'hFFFF_FFFF);
      exp_rd(A_STAT, 32'h0001_0000, "R3 rising adds nothing");
      wr(A_STAT, 32'h0);
      exp_rd(A_STAT, 32'h0001_0000, "R9 zero write keeps status");
      wr(A_STAT, 32'h0001_0000);
      exp_rd(A_STAT, 32'h0, "R9 clear pin 16");
      // R4 both edges on pin 1
      wr(A_BOTH, 32'h0000_0002);
      drive(32'hFFFF_FFFD);
      exp_rd(A_STAT, 32'h2, "R4 falling with both set");
      wr(A_STAT, 32'h2);
      drive(32'hFFFF_FFFF);
      exp_rd(A_STAT, 32'h2, "R4 rising with both set");
      wr(A_STAT, 32'h2);
      // R10 detection while masked, pin 2
      wr(A_MSET, 32'h0000_0004);
      exp_rd(A_MASK, 32'h4, "R6 mask strobe sets bit 2");
      drive(32'hFFFF_FFFB);
      drive(32'hFFFF_FFFF);
      exp_rd(A_STAT, 32'h4, "R10 status latches while masked");
      exp_irq(1'b0, "R8 masked status gives no irq");
      wr(A_UNM, 32'h0);
      exp_rd(A_MASK, 32'h4, "R6 zero unmask write no effect");
      wr(A_MSET, 32'h0);
      exp_rd(A_MASK, 32'h4, "R6 zero mask write no effect");
      wr(A_UNM, 32'h4);
      exp_irq(1'b1, "R10 unmask raises pending irq");
      wr(A_STAT, 32'h4);
      // R5 level high on pin 3, both bit set to show it is ignored
      drive(32'hFFFF_FFF7);
      wr(A_BOTH, 32'h0000_000A);
      wr(A_TRIG, 32'hFFFF_FFF7);
      exp_rd(A_STAT, 32'h0, "R5 level high inactive, both ignored");
      drive(32'hFFFF_FFFF);
      exp_rd(A_STAT, 32'h8, "R5 level high sets status");
      wr(A_STAT, 32'h8);
      exp_rd(A_STAT, 32'h8, "R11 level still active re-sets");
      drive(32'hFFFF_FFF7);
      wr(A_STAT, 32'h8);
      exp_rd(A_STAT, 32'h0, "R5 level high gone, clear holds");
      wr(A_POL, 32'h0000_FFF7);
      exp_rd(A_STAT, 32'h8, "R5 level low sets status");
      drive(32'hFFFF_FFFF);
      wr(A_STAT, 32'h8);
      exp_rd(A_STAT, 32'h0, "R5 level low gone, clear holds");
      // R12 edge on pin 0 in same cycle as clear of bit 0
      drive(32'hFFFF_FFFE);
      @(posedge clk); #1;
      pins = 32'hFFFF_FFFF;
      wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h1;
      @(posedge clk); #1;
      wr_en = 1'b0;
      exp_rd(A_STAT, 32'h1, "R12 event beats clear");
      // R6 mask everything
      wr(A_MSET, 32'hFFFF_FFFF);
      exp_rd(A_MASK, 32'hFFFF_FFFF, "R6 all ones masks every pin");
      exp_irq(1'b0, "R8 all masked gives no irq");
      exp_rd(3'd7, 32'h0, "R7 unused address reads 0");
      @(posedge clk); @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule